// File: doc/BRIEF.md
# Flash write-status bit generator

This block is the device-side status source of a parallel NOR flash while an embedded program or erase runs inside the part. A host command sequence ends with a one-cycle `start` pulse that stands for the last write strobe. The pulse carries the kind of operation, the datum and address for a program, and the sector selection for an erase. From that point the block is busy for a number of clock cycles set by parameters. During that time, host reads return a status byte instead of array data. Protection flags for each sector decide whether real work is done or whether the block only runs a fixed protection timeout and then falls back to array reading with nothing changed.

The status byte has three kinds of content. Bit 7 is the polling bit. During a program it is the complement of the programmed bit 7. During an erase it is 0. While an erase is suspended it is 1. Bit 5 reports that the work time has passed an internal limit. All other bits read 0. Only reads at a valid address get status; any other address reads all ones. Outside busy periods the block is in array-read mode and returns a result word. This word holds the datum of the last completed program, or all ones after a completed erase. An erase can be suspended and resumed; suspension freezes the remaining time.

Top module: `flash_wstat_gen`

## Requirements
- R1: While a program on an unprotected sector runs, a read at the program address returns 8'h80 when bit 7 of the datum is 0 and 8'h00 when it is 1 (bit 7 is the inverted datum bit 7, bit 5 is the limit flag, all other bits are 0).
- R2: A program on an unprotected sector keeps `busy` high for exactly PROG_CYC cycles, starting the cycle after `start`. After that, `status_mode` is 0 and every read returns the programmed datum.
- R3: While an erase with unprotected targets runs, a read at a valid address returns 8'h00. `busy` stays high for ERASE_CYC cycles multiplied by the number of targeted unprotected sectors.
- R4: A `susp_req` pulse during a running erase with unprotected targets drops `busy` from the next cycle while `status_mode` stays 1. Valid reads then return 8'h80. The remaining time is frozen until `resume_req`, so the total busy time is unchanged.
- R5: `busy` and `status_mode` are 0 until a `start` arrives in idle. A `start` while the block is not idle, or one with `op_kind` 3, is ignored. `op_kind` encodings: 0 program, 1 sector erase, 2 chip erase.
- R6: A program whose address lies in a protected sector keeps `busy` high for PPROT_CYC cycles, with polling bit 7 inverted. It then returns to array read with the result word unchanged.
- R7: An erase whose targets are all protected keeps `busy` high for EPROT_CYC cycles, with polling bit 7 equal to 0. It then returns to array read with the result word unchanged.
- R8: An erase with some targets protected counts only the unprotected targets toward its duration. When it completes, the result word becomes 8'hFF.
- R9: The valid status address is the exact program address for a program, and any selected sector for a sector erase. For a chip erase it is any unprotected sector, or any sector when all are protected. The sector is address bits [ADDR_W-1 -: SECT_BITS]. A busy-time read elsewhere returns 8'hFF.
- R10: After LIMIT_CYC running cycles of an operation that does real work, bit 5 of status reads is 1. The flag is cleared when the block returns to array read, so the next operation starts with bit 5 at 0.
- R11: `susp_req` has no effect during a program or during a protection timeout.
- R12: After reset, `busy` is 0, `status_mode` is 0 and `stat_q` is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command accepted (final write strobe) |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 chip erase |
| prog_data | input | 8 | Datum to program |
| prog_addr | input | ADDR_W | Program address |
| sect_sel | input | 2**SECT_BITS | Sectors selected for sector erase |
| sect_prot | input | 2**SECT_BITS | Per-sector protection flags |
| susp_req | input | 1 | Erase suspend request pulse |
| resume_req | input | 1 | Erase resume request pulse |
| rd_stb | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Host read address |
| stat_q | output | 8 | Read data, status or result word |
| busy | output | 1 | Embedded algorithm running |
| status_mode | output | 1 | 1 while reads return status, 0 for array read |

## Verification
A wrong internal state appears at the ports in two ways. The first is a polling byte of the wrong polarity or content: 8'h80 against 8'h00 against 8'hFF, which is visible on the first read after the fault. The second is a `busy` window whose length differs from the one computed from the parameters and the protection pattern, which is visible on the cycle `busy` falls. A timer that keeps running during suspend, or a work count that includes protected sectors, changes that window length. A result word that is overwritten after a protection timeout shows on the first array read after `status_mode` drops. A limit flag that is not cleared shows as 8'hA0 on the first status read of the next program.

// File: rtl/fws_pkg.sv
package fws_pkg;

   typedef enum logic [1:0] {
      OP_PROG   = 2'd0,
      OP_SERASE = 2'd1,
      OP_CERASE = 2'd2,
      OP_RSVD   = 2'd3
   } fws_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_SUSP = 2'd2
   } fws_state_e;

   localparam logic [7:0] FILL_BYTE = 8'hFF;

   // status layout: bit 7 polling, bit 5 limit flag, rest zero
   function automatic logic [7:0] pack_status(input logic poll, input logic lim);
      return {poll, 1'b0, lim, 5'b00000};
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fws_sector_eval.sv
module fws_sector_eval
   import fws_pkg::*;
#(
   parameter int NSECT = 8,
   parameter int SC_W  = 4
) (
   input  fws_op_e          op,
   input  logic [NSECT-1:0] sel,
   input  logic [NSECT-1:0] prot,
   output logic [NSECT-1:0] valid_mask,
   output logic [SC_W-1:0]  work_cnt,
   output logic             none_work
);

   logic [NSECT-1:0] tgt;
   logic [NSECT-1:0] work;

   initial begin
      assert (NSECT >= 2) else $error("fws_sector_eval: NSECT must be at least 2");
      assert ((1 << SC_W) > NSECT) else $error("fws_sector_eval: SC_W too narrow");
   end

   for (genvar i = 0; i < NSECT; i++) begin : g_sect
      assign tgt[i]  = (op == OP_CERASE) ? 1'b1 : sel[i];
      assign work[i] = tgt[i] & ~prot[i];
   end

   always_comb begin
      work_cnt = '0;
      for (int i = 0; i < NSECT; i++) begin
         work_cnt = work_cnt + SC_W'(work[i]);
      end
   end

   assign none_work = (work == '0);

   always_comb begin
      if (op == OP_CERASE) begin
         valid_mask = none_work ? '1 : work;
      end else begin
         valid_mask = sel;
      end
   end

endmodule

// File: rtl/fws_busy_timer.sv
module fws_busy_timer #(
   parameter int CNT_W     = 9,
   parameter int LIM_W     = 8,
   parameter int LIMIT_CYC = 200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   input  logic             work,
   output logic             last,
   output logic             lim_flag
);

   logic [CNT_W-1:0] cnt;
   logic [LIM_W-1:0] elapsed;

   initial begin
      assert (LIMIT_CYC >= 2) else $error("fws_busy_timer: LIMIT_CYC must be at least 2");
      assert ((1 << LIM_W) > LIMIT_CYC) else $error("fws_busy_timer: LIM_W too narrow");
   end

   assign last = run && (cnt == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (run && (cnt != '0)) begin
         cnt <= cnt - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed  <= '0;
         lim_flag <= 1'b0;
      end else if (load || last) begin
         elapsed  <= '0;
         lim_flag <= 1'b0;
      end else if (run && work && !lim_flag) begin
         elapsed <= elapsed + LIM_W'(1);
         if (elapsed == LIM_W'(LIMIT_CYC - 1)) begin
            lim_flag <= 1'b1;
         end
      end
   end

   // R10
   lim_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lim_flag && !last && !load) |=> lim_flag);

   // R4
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(cnt));

endmodule

// File: rtl/fws_read_port.sv
module fws_read_port
   import fws_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int SECT_BITS = 3,
   parameter int NSECT     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              status_mode,
   input  logic              is_prog,
   input  logic [ADDR_W-1:0] prog_addr,
   input  logic [NSECT-1:0]  valid_mask,
   input  logic              poll,
   input  logic              lim,
   input  logic [7:0]        res_word,
   output logic [7:0]        stat_q
);

   logic [SECT_BITS-1:0] rd_sect;
   logic                 addr_ok;
   logic [7:0]           rd_next;

   assign rd_sect = rd_addr[ADDR_W-1 -: SECT_BITS];
   assign addr_ok = is_prog ? (rd_addr == prog_addr) : valid_mask[rd_sect];

   always_comb begin
      if (!status_mode) begin
         rd_next = res_word;
      end else if (addr_ok) begin
         rd_next = pack_status(poll, lim);
      end else begin
         rd_next = FILL_BYTE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= FILL_BYTE;
      end else if (rd_stb) begin
         stat_q <= rd_next;
      end
   end

   // R9
   bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && status_mode && !addr_ok) |=> (stat_q == FILL_BYTE));

   // R1
   status_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && status_mode) |=> (stat_q[6] == 1'b1 || stat_q[4:0] == 5'b0));

endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen
   import fws_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int SECT_BITS = 3,
   parameter int PROG_CYC  = 20,
   parameter int ERASE_CYC = 40,
   parameter int PPROT_CYC = 30,
   parameter int EPROT_CYC = 60,
   parameter int LIMIT_CYC = 200
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [1:0]                  op_kind,
   input  logic [7:0]                  prog_data,
   input  logic [ADDR_W-1:0]           prog_addr,
   input  logic [(1<<SECT_BITS)-1:0]   sect_sel,
   input  logic [(1<<SECT_BITS)-1:0]   sect_prot,
   input  logic                        susp_req,
   input  logic                        resume_req,
   input  logic                        rd_stb,
   input  logic [ADDR_W-1:0]           rd_addr,
   output logic [7:0]                  stat_q,
   output logic                        busy,
   output logic                        status_mode
);

   localparam int NSECT     = 1 << SECT_BITS;
   localparam int SC_W      = $clog2(NSECT + 1);
   localparam int ERASE_MAX = ERASE_CYC * NSECT;
   localparam int MAX_DUR   = max2(max2(PROG_CYC, PPROT_CYC), max2(EPROT_CYC, ERASE_MAX));
   localparam int CNT_W     = $clog2(MAX_DUR + 1);
   localparam int LIM_W     = $clog2(LIMIT_CYC + 1);

   initial begin
      assert (SECT_BITS >= 1 && SECT_BITS < ADDR_W)
         else $error("flash_wstat_gen: SECT_BITS out of range");
      assert (PROG_CYC >= 2 && ERASE_CYC >= 2 && PPROT_CYC >= 2 && EPROT_CYC >= 2)
         else $error("flash_wstat_gen: busy durations must be at least 2");
      assert (LIMIT_CYC > PROG_CYC)
         else $error("flash_wstat_gen: limit must exceed program time");
   end

   fws_op_e              op_in;
   fws_op_e              op_q;
   fws_state_e           state;
   fws_state_e           state_nx;
   logic [7:0]           d_q;
   logic [ADDR_W-1:0]    addr_q;
   logic [NSECT-1:0]     mask_q;
   logic                 prot_q;
   logic [7:0]           res_word;

   logic [SECT_BITS-1:0] prog_sect;
   logic                 prog_prot;
   logic [NSECT-1:0]     valid_in;
   logic [SC_W-1:0]      work_cnt;
   logic                 none_work;
   logic                 accept;
   logic                 is_prog_in;
   logic                 prot_in;
   logic [CNT_W-1:0]     load_val;
   logic                 run;
   logic                 last;
   logic                 lim_flag;
   logic                 susp_ok;
   logic                 poll;

   assign op_in      = fws_op_e'(op_kind);
   assign prog_sect  = prog_addr[ADDR_W-1 -: SECT_BITS];
   assign prog_prot  = sect_prot[prog_sect];
   assign is_prog_in = (op_in == OP_PROG);
   assign accept     = start && (state == ST_IDLE) && (op_in != OP_RSVD);

   fws_sector_eval #(
      .NSECT (NSECT),
      .SC_W  (SC_W)
   ) u_sect (
      .op         (op_in),
      .sel        (sect_sel),
      .prot       (sect_prot),
      .valid_mask (valid_in),
      .work_cnt   (work_cnt),
      .none_work  (none_work)
   );

   always_comb begin
      if (is_prog_in) begin
         prot_in  = prog_prot;
         load_val = prog_prot ? CNT_W'(PPROT_CYC) : CNT_W'(PROG_CYC);
      end else begin
         prot_in  = none_work;
         load_val = none_work ? CNT_W'(EPROT_CYC)
                              : CNT_W'(ERASE_CYC) * CNT_W'(work_cnt);
      end
   end

   assign run = (state == ST_RUN);

   fws_busy_timer #(
      .CNT_W     (CNT_W),
      .LIM_W     (LIM_W),
      .LIMIT_CYC (LIMIT_CYC)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (load_val),
      .run      (run),
      .work     (!prot_q),
      .last     (last),
      .lim_flag (lim_flag)
   );

   assign susp_ok = run && (op_q != OP_PROG) && !prot_q;

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE: if (accept) state_nx = ST_RUN;
         ST_RUN: begin
            if (last) begin
               state_nx = ST_IDLE;
            end else if (susp_req && susp_ok) begin
               state_nx = ST_SUSP;
            end
         end
         ST_SUSP: if (resume_req) state_nx = ST_RUN;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
      end else begin
         state <= state_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_PROG;
         d_q    <= '0;
         addr_q <= '0;
         mask_q <= '0;
         prot_q <= 1'b0;
      end else if (accept) begin
         op_q   <= op_in;
         d_q    <= prog_data;
         addr_q <= prog_addr;
         mask_q <= valid_in;
         prot_q <= prot_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_word <= FILL_BYTE;
      end else if (last && !prot_q) begin
         res_word <= (op_q == OP_PROG) ? d_q : FILL_BYTE;
      end
   end

   always_comb begin
      if (state == ST_SUSP) begin
         poll = 1'b1;
      end else if (op_q == OP_PROG) begin
         poll = ~d_q[7];
      end else begin
         poll = 1'b0;
      end
   end

   assign busy        = run;
   assign status_mode = (state != ST_IDLE);

   fws_read_port #(
      .ADDR_W    (ADDR_W),
      .SECT_BITS (SECT_BITS),
      .NSECT     (NSECT)
   ) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_stb      (rd_stb),
      .rd_addr     (rd_addr),
      .status_mode (status_mode),
      .is_prog     (op_q == OP_PROG),
      .prog_addr   (addr_q),
      .valid_mask  (mask_q),
      .poll        (poll),
      .lim         (lim_flag),
      .res_word    (res_word),
      .stat_q      (stat_q)
   );

   // R5
   restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_mode && start) |=> ($stable(op_q) && $stable(d_q) && $stable(addr_q)));

   // R4
   suspend_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (susp_ok && susp_req && !last) |=> (!busy && status_mode));

   // R11
   nosusp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !susp_ok && !last) |=> busy);

   // R6
   prot_nochange_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last && prot_q) |=> $stable(res_word));

   // R2
   done_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !prot_q && op_q == OP_PROG) |=> (res_word == $past(d_q) && !status_mode));

endmodule

// File: tb/flash_wstat_gen_tb.sv
module flash_wstat_gen_tb;

   localparam int ADDR_W    = 12;
   localparam int SECT_BITS = 3;
   localparam int NSECT     = 1 << SECT_BITS;
   localparam int PROG_CYC  = 20;
   localparam int ERASE_CYC = 40;
   localparam int PPROT_CYC = 30;
   localparam int EPROT_CYC = 60;
   localparam int LIMIT_CYC = 200;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [1:0]        op_kind = 2'd0;
   logic [7:0]        prog_data = 8'h00;
   logic [ADDR_W-1:0] prog_addr = '0;
   logic [NSECT-1:0]  sect_sel = '0;
   logic [NSECT-1:0]  sect_prot = '0;
   logic              susp_req = 1'b0;
   logic              resume_req = 1'b0;
   logic              rd_stb = 1'b0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [7:0]        stat_q;
   logic              busy;
   logic              status_mode;

   int n_chk = 0;
   int n_err = 0;
   int busy_cnt = 0;
   logic rd_seen = 1'b0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   bit         finished = 1'b0;

   always #5 clk = ~clk;

   flash_wstat_gen #(
      .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .PROG_CYC(PROG_CYC),
      .ERASE_CYC(ERASE_CYC), .PPROT_CYC(PPROT_CYC), .EPROT_CYC(EPROT_CYC),
      .LIMIT_CYC(LIMIT_CYC)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
      .prog_data(prog_data), .prog_addr(prog_addr), .sect_sel(sect_sel),
      .sect_prot(sect_prot), .susp_req(susp_req), .resume_req(resume_req),
      .rd_stb(rd_stb), .rd_addr(rd_addr), .stat_q(stat_q), .busy(busy),
      .status_mode(status_mode)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(posedge clk) rd_seen <= rd_stb;

   always @(negedge clk) begin
      if (busy) busy_cnt++;
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            check("monitor: read without expectation", 32'd1, 32'd0);
         end else begin
            check(tag_q.pop_front(), {24'd0, stat_q}, {24'd0, exp_q.pop_front()});
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string tag);
      rd_addr = a;
      rd_stb  = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic start_op(input logic [1:0] k, input logic [7:0] d, input logic [ADDR_W-1:0] a,
                           input logic [NSECT-1:0] sel, input logic [NSECT-1:0] prot);
      op_kind = k; prog_data = d; prog_addr = a; sect_sel = sel; sect_prot = prot;
      busy_cnt = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done;
      while (status_mode) @(negedge clk);
      tick(1);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R12 reset state
      check("R12 busy after reset", {31'd0, busy}, 32'd0);
      check("R12 mode after reset", {31'd0, status_mode}, 32'd0);
      check("R12 stat_q after reset", {24'd0, stat_q}, 32'hFF);
      // R5 reserved op ignored
      start_op(2'd3, 8'h00, 12'h000, 8'h01, 8'h00);
      tick(1);
      check("R5 reserved op ignored", {31'd0, status_mode}, 32'd0);

      // R1 R2 program, datum bit7 = 0
      start_op(2'd0, 8'h5A, 12'h123, 8'h00, 8'h00);
      tick(1);
      rd(12'h123, 8'h80, "R1 program status d7=0");
      rd(12'h124, 8'hFF, "R9 program wrong address");
      op_kind = 2'd1; sect_sel = 8'hFF; start = 1'b1;
      @(negedge clk); start = 1'b0;
      rd(12'h123, 8'h80, "R5 restart ignored");
      susp_req = 1'b1;
      @(negedge clk); susp_req = 1'b0;
      check("R11 suspend ignored during program", {31'd0, busy}, 32'd1);
      wait_done();
      check("R2 program busy length", busy_cnt, PROG_CYC);
      rd(12'h7FF, 8'h5A, "R2 array read after program");

      // R1 R2 program, datum bit7 = 1
      start_op(2'd0, 8'hC3, 12'h045, 8'h00, 8'h00);
      rd(12'h045, 8'h00, "R1 program status d7=1");
      wait_done();
      rd(12'h045, 8'hC3, "R2 array read second program");

      // R6 protected program
      start_op(2'd0, 8'h11, 12'h4A0, 8'h00, 8'h04);
      rd(12'h4A0, 8'h80, "R6 protected program polling");
      susp_req = 1'b1;
      @(negedge clk); susp_req = 1'b0;
      check("R11 suspend ignored in timeout", {31'd0, busy}, 32'd1);
      wait_done();
      check("R6 protected program busy length", busy_cnt, PPROT_CYC);
      rd(12'h4A0, 8'hC3, "R6 result unchanged");

      // R3 R8 partial protection: sectors 1,3,5 selected, 3 protected
      start_op(2'd1, 8'h00, 12'h000, 8'b0010_1010, 8'b0000_1000);
      rd(12'h600, 8'h00, "R3 erase status protected-but-selected");
      rd(12'h000, 8'hFF, "R9 erase unselected sector");
      rd(12'hA10, 8'h00, "R3 erase status sector 5");
      wait_done();
      check("R8 partial erase busy length", busy_cnt, 2 * ERASE_CYC);
      rd(12'h000, 8'hFF, "R8 result after erase");

      // R7 all-protected erase
      start_op(2'd0, 8'h3C, 12'h010, 8'h00, 8'h00);
      wait_done();
      start_op(2'd1, 8'h00, 12'h000, 8'b0000_0100, 8'b0000_0100);
      rd(12'h400, 8'h00, "R7 protected erase polling");
      wait_done();
      check("R7 protected erase busy length", busy_cnt, EPROT_CYC);
      rd(12'h400, 8'h3C, "R7 result unchanged");

      // R4 suspend and resume
      start_op(2'd1, 8'h00, 12'h000, 8'b0011_0000, 8'h00);
      tick(10);
      rd(12'h800, 8'h00, "R4 erase running before suspend");
      susp_req = 1'b1;
      @(negedge clk); susp_req = 1'b0;
      check("R4 busy low in suspend", {31'd0, busy}, 32'd0);
      check("R4 mode high in suspend", {31'd0, status_mode}, 32'd1);
      rd(12'hA00, 8'h80, "R4 suspend polling");
      rd(12'h000, 8'hFF, "R9 suspend unselected");
      tick(25);
      check("R4 still suspended", {31'd0, busy}, 32'd0);
      resume_req = 1'b1;
      @(negedge clk); resume_req = 1'b0;
      check("R4 busy after resume", {31'd0, busy}, 32'd1);
      wait_done();
      check("R4 total busy length", busy_cnt, 2 * ERASE_CYC);

      // R10 chip erase beyond limit, sector 6 protected
      start_op(2'd2, 8'h00, 12'h000, 8'h00, 8'b0100_0000);
      tick(5);
      rd(12'hC00, 8'hFF, "R9 chip erase protected sector");
      rd(12'h200, 8'h00, "R10 flag low early");
      while (busy_cnt < LIMIT_CYC + 5) @(negedge clk);
      rd(12'h200, 8'h20, "R10 flag set after limit");
      wait_done();
      check("R3 chip erase busy length", busy_cnt, 7 * ERASE_CYC);
      start_op(2'd0, 8'h5A, 12'h123, 8'h00, 8'h00);
      rd(12'h123, 8'h80, "R10 flag cleared for next op");
      wait_done();

      // R7 R9 chip erase all protected
      start_op(2'd2, 8'h00, 12'h000, 8'h00, 8'hFF);
      rd(12'hE00, 8'h00, "R9 all-protected chip erase any sector");
      wait_done();
      check("R7 all-protected chip erase length", busy_cnt, EPROT_CYC);
      rd(12'hE00, 8'h5A, "R7 result unchanged after chip timeout");

      tick(3);
      check("scoreboard drained", exp_q.size(), 0);
      finish_run();
   end

endmodule